// File: doc/BRIEF.md
# Shifter Operand Unit

This block forms the second ALU operand of a 32-bit RISC data path, together with the shifter carry that logical operations copy into the C flag. The operand comes from one of three sources. The first is the Rm register shifted by a 5-bit amount held in the instruction. The second is Rm shifted by an amount read from the low byte of another register, Rs. The third is an 8-bit constant rotated right by twice a 4-bit rotate field. Three shift kinds are built: logical left, logical right and arithmetic right. The encodings that are special to the architecture are built as well.

The unit is purely combinational. Decode, execute or a reference model reads the operand and the carry in the same cycle as the inputs. Any rotate shift kind raises a separate `unsupported` output, so the sequencer can trap the instruction. This covers rotate by register and rotate-with-extend, which the immediate-amount rotate of zero encodes.

Top module: `sop_unit`

## Requirements
- R1: Shift kind codes are 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate. With the immediate source selected and a shift amount field of 0, logical left passes Rm through unchanged, and the carry-out equals the incoming C.
- R2: With the immediate source selected and a shift amount field of 0, logical right and arithmetic right act as a shift by 32. Logical right gives 0. Arithmetic right gives 32 copies of Rm bit 31. In both cases the carry-out is Rm bit 31.
- R3: For a shift amount n from 1 to 31, from either source, the result is Rm shifted by n. Logical shifts fill with zeros and arithmetic right fills with the sign. The carry-out is the last bit shifted out: Rm bit 32-n for a left shift, and Rm bit n-1 for a right shift.
- R4: In register-amount mode the amount is Rs bits 7..0, and Rs bits 31..8 have no effect. An amount of 0 passes Rm through with carry-out equal to the incoming C, for every shift kind except rotate.
- R5: A register-amount logical left by exactly 32 gives 0 with carry-out Rm bit 0. By 33 to 255 it gives 0 with carry-out 0.
- R6: A register-amount logical right by exactly 32 gives 0 with carry-out Rm bit 31. By 33 to 255 it gives 0 with carry-out 0.
- R7: A register-amount arithmetic right by 32 to 255 gives 32 copies of Rm bit 31, with carry-out Rm bit 31.
- R8: On the rotated-constant path the operand is the 8-bit constant, zero-extended to 32 bits and rotated right by twice the rotate field. The carry-out is the incoming C when the rotate field is 0, and result bit 31 otherwise.
- R9: When the constant select is high, the rotated-constant path wins. Rm, Rs, the shift kind, the amount field and the register-amount select then have no effect, and `unsupported` is 0.
- R10: With the constant select low and shift kind 11, `unsupported` is 1, the operand equals Rm and the carry-out equals the incoming C. For every other shift kind `unsupported` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rmVal | input | 32 | Value of the register to be shifted |
| rsVal | input | 32 | Register supplying the shift amount in register-amount mode |
| shiftType | input | 2 | Shift kind: 00 LSL, 01 LSR, 10 ASR, 11 rotate |
| shiftImm | input | 5 | Shift amount field from the instruction |
| regShiftSel | input | 1 | 1 takes the amount from rsVal[7:0] |
| immSel | input | 1 | 1 selects the rotated-constant path |
| imm8 | input | 8 | Constant for the rotated path |
| rot4 | input | 4 | Rotate field; rotation is twice this value |
| carryIn | input | 1 | Incoming C flag |
| operand | output | 32 | Generated second operand |
| carryOut | output | 1 | Shifter carry-out |
| unsupported | output | 1 | Rotate shift kind requested on a shift path |

## Verification
Two functions can fall in the same cycle. One is the constant-select priority. The other is the shift decode, which would raise `unsupported` or pick a boundary amount. The bench provokes both together: it drives the constant select high while the shift kind is 11 and Rs holds amounts of 0, 32 and above 32. It judges the result by requiring the rotated constant, its carry rule and a low `unsupported` flag. The bench also crosses each immediate amount of 0 with the register-amount select. This shows that the zero-means-32 rule applies to the instruction field only. It does not apply to a zero read from Rs.

// File: rtl/sop_pkg.sv
package sop_pkg;

  typedef enum logic [1:0] {
    SHK_LSL = 2'b00,
    SHK_LSR = 2'b01,
    SHK_ASR = 2'b10,
    SHK_ROR = 2'b11
  } shiftKind_t;

  // strobes from control to datapath, at most one of the select group high
  typedef struct packed {
    logic useImm;      // rotated constant path
    logic passThru;    // operand = Rm, carry = C
    logic smallShift;  // amount 1..DATA_W-1
    logic exactFull;   // amount exactly DATA_W
    logic beyondFull;  // amount above DATA_W
    logic dirLeft;     // logical left shift
    logic arith;       // arithmetic right shift
    logic unsupported; // rotate kind on a shift path
  } sopStrobes_t;

endpackage

// File: rtl/sop_ctrl.sv
module sop_ctrl
  import sop_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int AMT_W    = 8,
  parameter int IMMAMT_W = 5
) (
  input  logic [1:0]          shiftType,
  input  logic [IMMAMT_W-1:0] shiftImm,
  input  logic [AMT_W-1:0]    rsAmt,
  input  logic                regShiftSel,
  input  logic                immSel,
  output sopStrobes_t         strobes,
  output logic [AMT_W-1:0]    amount
);

  localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(DATA_W);

  shiftKind_t kind;
  logic       isRor;
  logic       immZeroRight;
  logic       shiftPath;

  always_comb begin
    kind         = shiftKind_t'(shiftType);
    isRor        = (kind == SHK_ROR);
    shiftPath    = !immSel && !isRor;
    amount       = regShiftSel ? rsAmt : AMT_W'(shiftImm);
    // the instruction field cannot encode 32, so zero stands in for it on right shifts
    immZeroRight = !regShiftSel && (shiftImm == '0) &&
                   (kind == SHK_LSR || kind == SHK_ASR);

    strobes             = '0;
    strobes.useImm      = immSel;
    strobes.unsupported = !immSel && isRor;
    strobes.dirLeft     = (kind == SHK_LSL);
    strobes.arith       = (kind == SHK_ASR);
    strobes.passThru    = strobes.unsupported ||
                          (shiftPath && amount == '0 && !immZeroRight);
    strobes.smallShift  = shiftPath && amount != '0 && amount < FULL_AMT;
    strobes.exactFull   = shiftPath && (amount == FULL_AMT || immZeroRight);
    strobes.beyondFull  = shiftPath && amount > FULL_AMT;
  end

endmodule

// File: rtl/sop_rshift.sv
module sop_rshift #(
  parameter int W  = 33,
  parameter int AW = 5
) (
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] amt,
  input  logic          fill,
  output logic [W-1:0]  dout
);

  logic [W-1:0] stg [AW+1];

  assign stg[0] = din;

  for (genvar k = 0; k < AW; k++) begin : g_stage
    localparam int STEP = 1 << k;
    assign stg[k+1] = amt[k] ? {{STEP{fill}}, stg[k][W-1:STEP]} : stg[k];
  end

  assign dout = stg[AW];

endmodule

// File: rtl/sop_dpath.sv
module sop_dpath
  import sop_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4
) (
  input  logic [DATA_W-1:0] rmVal,
  input  logic [AMT_W-1:0]  amount,
  input  logic [IMM_W-1:0]  imm8,
  input  logic [ROT_W-1:0]  rot4,
  input  logic              carryIn,
  input  sopStrobes_t       strobes,
  output logic [DATA_W-1:0] operand,
  output logic              carryOut
);

  localparam int SH_W  = $clog2(DATA_W);
  localparam int EXT_W = DATA_W + 1;   // one guard bit catches the last bit out
  localparam int RA_W  = ROT_W + 1;

  logic [DATA_W-1:0] revRm;
  logic [DATA_W-1:0] shIn;
  logic [EXT_W-1:0]  shOut;
  logic [DATA_W-1:0] shBody;
  logic [DATA_W-1:0] revBody;
  logic [DATA_W-1:0] smallRes;
  logic              smallCarry;
  logic              signBit;

  assign signBit = rmVal[DATA_W-1];

  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign revRm[i]   = rmVal[DATA_W-1-i];
    assign revBody[i] = shBody[DATA_W-1-i];
  end

  // left shifts reuse the right shifter on the bit-reversed word
  assign shIn = strobes.dirLeft ? revRm : rmVal;

  sop_rshift #(.W(EXT_W), .AW(SH_W)) u_rsh (
    .din  ({shIn, 1'b0}),
    .amt  (amount[SH_W-1:0]),
    .fill (strobes.arith & signBit),
    .dout (shOut)
  );

  assign shBody     = shOut[EXT_W-1:1];
  assign smallCarry = shOut[0];
  assign smallRes   = strobes.dirLeft ? revBody : shBody;

  // rotated constant
  logic [DATA_W-1:0]   immExt;
  logic [2*DATA_W-1:0] immDbl;
  logic [RA_W-1:0]     rotAmt;
  logic [DATA_W-1:0]   immRes;
  logic                immCarry;

  assign immExt   = DATA_W'(imm8);
  assign rotAmt   = {rot4, 1'b0};
  assign immDbl   = {immExt, immExt} >> rotAmt;
  assign immRes   = immDbl[DATA_W-1:0];
  assign immCarry = (rot4 == '0) ? carryIn : immRes[DATA_W-1];

  always_comb begin
    operand  = rmVal;
    carryOut = carryIn;
    if (strobes.useImm) begin
      operand  = immRes;
      carryOut = immCarry;
    end else if (strobes.passThru) begin
      operand  = rmVal;
      carryOut = carryIn;
    end else if (strobes.smallShift) begin
      operand  = smallRes;
      carryOut = smallCarry;
    end else if (strobes.exactFull) begin
      operand  = strobes.arith ? {DATA_W{signBit}} : '0;
      carryOut = strobes.dirLeft ? rmVal[0] : signBit;
    end else if (strobes.beyondFull) begin
      operand  = strobes.arith ? {DATA_W{signBit}} : '0;
      carryOut = strobes.arith & signBit;
    end
  end

endmodule

// File: rtl/sop_unit.sv
module sop_unit
  import sop_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int AMT_W    = 8,
  parameter int IMMAMT_W = 5,
  parameter int IMM_W    = 8,
  parameter int ROT_W    = 4
) (
  input  logic [DATA_W-1:0]   rmVal,
  input  logic [DATA_W-1:0]   rsVal,
  input  logic [1:0]          shiftType,
  input  logic [IMMAMT_W-1:0] shiftImm,
  input  logic                regShiftSel,
  input  logic                immSel,
  input  logic [IMM_W-1:0]    imm8,
  input  logic [ROT_W-1:0]    rot4,
  input  logic                carryIn,
  output logic [DATA_W-1:0]   operand,
  output logic                carryOut,
  output logic                unsupported
);

  sopStrobes_t      strobes;
  logic [AMT_W-1:0] amount;

  sop_ctrl #(.DATA_W(DATA_W), .AMT_W(AMT_W), .IMMAMT_W(IMMAMT_W)) u_ctrl (
    .shiftType   (shiftType),
    .shiftImm    (shiftImm),
    .rsAmt       (rsVal[AMT_W-1:0]),
    .regShiftSel (regShiftSel),
    .immSel      (immSel),
    .strobes     (strobes),
    .amount      (amount)
  );

  sop_dpath #(.DATA_W(DATA_W), .AMT_W(AMT_W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_dpath (
    .rmVal    (rmVal),
    .amount   (amount),
    .imm8     (imm8),
    .rot4     (rot4),
    .carryIn  (carryIn),
    .strobes  (strobes),
    .operand  (operand),
    .carryOut (carryOut)
  );

  assign unsupported = strobes.unsupported;

endmodule

// File: rtl/sop_unit_chk.sv
module sop_unit_chk #(
  parameter int DATA_W   = 32,
  parameter int AMT_W    = 8,
  parameter int IMMAMT_W = 5,
  parameter int IMM_W    = 8,
  parameter int ROT_W    = 4
) (
  input logic [DATA_W-1:0]   rmVal,
  input logic [DATA_W-1:0]   rsVal,
  input logic [1:0]          shiftType,
  input logic [IMMAMT_W-1:0] shiftImm,
  input logic                regShiftSel,
  input logic                immSel,
  input logic [IMM_W-1:0]    imm8,
  input logic [ROT_W-1:0]    rot4,
  input logic                carryIn,
  input logic [DATA_W-1:0]   operand,
  input logic                carryOut,
  input logic                unsupported
);

  localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(DATA_W);

  logic known;
  logic [AMT_W-1:0] rAmt;

  assign rAmt  = rsVal[AMT_W-1:0];
  assign known = !$isunknown({rmVal, rsVal, shiftType, shiftImm, regShiftSel,
                              immSel, imm8, rot4, carryIn, operand, carryOut,
                              unsupported});

  always_comb begin
    if (known) begin
      // R10: rotate kind on a shift path flags and passes through
      p_ror_flag_r10: assert (unsupported == (!immSel && shiftType == 2'b11))
        else $error("unsupported flag mismatch");
      if (unsupported) begin
        p_ror_pass_r10: assert (operand == rmVal && carryOut == carryIn)
          else $error("unsupported case not passed through");
      end
      // R8: unrotated constant keeps C
      if (immSel && rot4 == '0) begin
        p_imm_norot_r8: assert (operand == DATA_W'(imm8) && carryOut == carryIn)
          else $error("unrotated constant wrong");
      end
      // R8: rotated constant carries its own top bit, and has as many ones as the constant
      if (immSel && rot4 != '0) begin
        p_imm_rot_r8: assert (carryOut == operand[DATA_W-1] &&
                              $countones(operand) == $countones(imm8))
          else $error("rotated constant carry or population wrong");
      end
      // R4: register amount zero passes through
      if (!immSel && regShiftSel && rAmt == '0 && shiftType != 2'b11) begin
        p_reg_zero_r4: assert (operand == rmVal && carryOut == carryIn)
          else $error("register amount zero not a pass-through");
      end
      // R5 R6: logical shifts beyond the width clear everything
      if (!immSel && regShiftSel && rAmt > FULL_AMT && shiftType[1] == 1'b0) begin
        p_beyond_log_r5: assert (operand == '0 && carryOut == 1'b0)
          else $error("logical shift beyond width wrong");
      end
      // R7: arithmetic right by the width or more fills with sign
      if (!immSel && regShiftSel && rAmt >= FULL_AMT && shiftType == 2'b10) begin
        p_asr_full_r7: assert (operand == {DATA_W{rmVal[DATA_W-1]}} &&
                               carryOut == rmVal[DATA_W-1])
          else $error("arithmetic fill wrong");
      end
      // R1: immediate left by zero
      if (!immSel && !regShiftSel && shiftImm == '0 && shiftType == 2'b00) begin
        p_lsl0_r1: assert (operand == rmVal && carryOut == carryIn)
          else $error("immediate left by zero wrong");
      end
    end
  end

endmodule

bind sop_unit sop_unit_chk #(
  .DATA_W(DATA_W), .AMT_W(AMT_W), .IMMAMT_W(IMMAMT_W), .IMM_W(IMM_W), .ROT_W(ROT_W)
) u_chk (.*);

// File: tb/sim_sop_unit.sv
`timescale 1ns/1ps
module sim_sop_unit;

  logic        clk = 1'b0;
  logic [31:0] rmVal = '0;
  logic [31:0] rsVal = '0;
  logic [1:0]  shiftType = '0;
  logic [4:0]  shiftImm = '0;
  logic        regShiftSel = 1'b0;
  logic        immSel = 1'b0;
  logic [7:0]  imm8 = '0;
  logic [3:0]  rot4 = '0;
  logic        carryIn = 1'b0;
  logic [31:0] operand;
  logic        carryOut;
  logic        unsupported;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sop_unit u0 (
    .rmVal(rmVal), .rsVal(rsVal), .shiftType(shiftType), .shiftImm(shiftImm),
    .regShiftSel(regShiftSel), .immSel(immSel), .imm8(imm8), .rot4(rot4),
    .carryIn(carryIn), .operand(operand), .carryOut(carryOut),
    .unsupported(unsupported)
  );

  // behavioural model: one bit per step, amounts counted as integers
  task automatic model(output logic [31:0] expOp, output logic expC,
                       output logic expU);
    logic [31:0] v;
    logic c;
    int amt;
    expU = 1'b0;
    c = carryIn;
    if (immSel) begin
      v = {24'd0, imm8};
      for (int i = 0; i < 2 * int'(rot4); i++) v = {v[0], v[31:1]};
      if (rot4 != 0) c = v[31];
    end else if (shiftType == 2'b11) begin
      expU = 1'b1;
      v = rmVal;
    end else begin
      v = rmVal;
      amt = regShiftSel ? int'(rsVal[7:0]) : int'(shiftImm);
      if (!regShiftSel && amt == 0 && shiftType != 2'b00) amt = 32;
      for (int i = 0; i < amt; i++) begin
        case (shiftType)
          2'b00:   begin c = v[31]; v = {v[30:0], 1'b0}; end
          2'b01:   begin c = v[0];  v = {1'b0, v[31:1]}; end
          default: begin c = v[0];  v = {v[31], v[31:1]}; end
        endcase
      end
    end
    expOp = v;
    expC  = c;
  endtask

  task automatic apply(input logic [31:0] rm, input logic [31:0] rs,
                       input logic [1:0] kind, input logic [4:0] ia,
                       input logic rsel, input logic isel, input logic [7:0] k8,
                       input logic [3:0] r4, input logic cin, input string req);
    logic [31:0] eOp;
    logic eC, eU;
    @(posedge clk);
    #1;
    rmVal = rm; rsVal = rs; shiftType = kind; shiftImm = ia;
    regShiftSel = rsel; immSel = isel; imm8 = k8; rot4 = r4; carryIn = cin;
    @(negedge clk);
    model(eOp, eC, eU);
    checks++;
    if (operand !== eOp || carryOut !== eC || unsupported !== eU) begin
      errors++;
      $display("FAIL %s: actual op=%h c=%b u=%b expected op=%h c=%b u=%b",
               req, operand, carryOut, unsupported, eOp, eC, eU);
    end
  endtask

  initial begin
    #(20.0 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // idle state with all inputs zero: operand zero, no carry, no flag (R1)
    apply(32'h0, 32'h0, 2'b00, 5'd0, 1'b0, 1'b0, 8'h0, 4'h0, 1'b0, "R1_idle");
    // R1: immediate left by zero, both carry values
    apply(32'h8000_0001, 32'h0, 2'b00, 5'd0, 1'b0, 1'b0, 8'h0, 4'h0, 1'b1, "R1");
    apply(32'h8000_0001, 32'h0, 2'b00, 5'd0, 1'b0, 1'b0, 8'h0, 4'h0, 1'b0, "R1");
    // R2: zero means 32 for right shifts
    apply(32'h8000_0000, 32'h0, 2'b01, 5'd0, 1'b0, 1'b0, 8'h0, 4'h0, 1'b0, "R2");
    apply(32'h8765_4321, 32'h0, 2'b10, 5'd0, 1'b0, 1'b0, 8'h0, 4'h0, 1'b0, "R2");
    apply(32'h7765_4321, 32'h0, 2'b10, 5'd0, 1'b0, 1'b0, 8'h0, 4'h0, 1'b1, "R2");
    // R3: every amount 1..31 for each kind, immediate and register source
    for (int n = 1; n < 32; n++) begin
      for (int k = 0; k < 3; k++) begin
        apply(32'hA5C3_0F96 ^ (n * 32'h0101_0101), 32'hFFFF_FF00 | n, 2'(k),
              5'(n), 1'b0, 1'b0, 8'h0, 4'h0, 1'b0, "R3");
        apply(32'h5A3C_F069 ^ (n * 32'h0011_0011), 32'hFFFF_FF00 | n, 2'(k),
              5'd0, 1'b1, 1'b0, 8'h0, 4'h0, 1'b1, "R3");
      end
    end
    // R4: register zero amount with junk in the upper Rs bits; zero field not turned into 32
    for (int k = 0; k < 3; k++) begin
      apply(32'h8000_0001, 32'hDEAD_BE00, 2'(k), 5'd0, 1'b1, 1'b0, 8'h0, 4'h0, 1'b1, "R4");
      apply(32'h8000_0001, 32'h1234_5600, 2'(k), 5'd7, 1'b1, 1'b0, 8'h0, 4'h0, 1'b0, "R4");
    end
    // R5: left by 32, 33, 255
    apply(32'h0000_0001, 32'd32, 2'b00, 5'd0, 1'b1, 1'b0, 8'h0, 4'h0, 1'b0, "R5");
    apply(32'hFFFF_FFFE, 32'd32, 2'b00, 5'd0, 1'b1, 1'b0, 8'h0, 4'h0, 1'b1, "R5");
    apply(32'hFFFF_FFFF, 32'd33, 2'b00, 5'd0, 1'b1, 1'b0, 8'h0, 4'h0, 1'b1, "R5");
    apply(32'hFFFF_FFFF, 32'd255, 2'b00, 5'd0, 1'b1, 1'b0, 8'h0, 4'h0, 1'b1, "R5");
    // R6: logical right by 32, 33, 200
    apply(32'h8000_0000, 32'd32, 2'b01, 5'd0, 1'b1, 1'b0, 8'h0, 4'h0, 1'b0, "R6");
    apply(32'h7FFF_FFFF, 32'd32, 2'b01, 5'd0, 1'b1, 1'b0, 8'h0, 4'h0, 1'b1, "R6");
    apply(32'hFFFF_FFFF, 32'd33, 2'b01, 5'd0, 1'b1, 1'b0, 8'h0, 4'h0, 1'b1, "R6");
    apply(32'hFFFF_FFFF, 32'd200, 2'b01, 5'd0, 1'b1, 1'b0, 8'h0, 4'h0, 1'b0, "R6");
    // R7: arithmetic right by 32 and above, both signs
    apply(32'h8000_0000, 32'd32, 2'b10, 5'd0, 1'b1, 1'b0, 8'h0, 4'h0, 1'b0, "R7");
    apply(32'h8000_0000, 32'd255, 2'b10, 5'd0, 1'b1, 1'b0, 8'h0, 4'h0, 1'b0, "R7");
    apply(32'h7FFF_FFFF, 32'd40, 2'b10, 5'd0, 1'b1, 1'b0, 8'h0, 4'h0, 1'b1, "R7");
    // R8: every rotate value with two constants and both carry values
    for (int r = 0; r < 16; r++) begin
      apply(32'h0, 32'h0, 2'b00, 5'd0, 1'b0, 1'b1, 8'hC3, 4'(r), 1'b1, "R8");
      apply(32'h0, 32'h0, 2'b00, 5'd0, 1'b0, 1'b1, 8'h01, 4'(r), 1'b0, "R8");
    end
    // R9: constant select beats rotate kind and large register amounts
    apply(32'hFFFF_FFFF, 32'd32, 2'b11, 5'd0, 1'b1, 1'b1, 8'h81, 4'h1, 1'b0, "R9");
    apply(32'h1234_5678, 32'd0, 2'b11, 5'd0, 1'b0, 1'b1, 8'h7F, 4'h0, 1'b1, "R9");
    apply(32'h8000_0000, 32'd99, 2'b10, 5'd3, 1'b1, 1'b1, 8'h40, 4'h4, 1'b1, "R9");
    // R10: rotate kind on both shift sources, including zero field
    apply(32'hCAFE_F00D, 32'd4, 2'b11, 5'd0, 1'b1, 1'b0, 8'h0, 4'h0, 1'b1, "R10");
    apply(32'hCAFE_F00D, 32'd0, 2'b11, 5'd0, 1'b0, 1'b0, 8'h0, 4'h0, 1'b0, "R10");
    apply(32'hCAFE_F00D, 32'd0, 2'b11, 5'd9, 1'b0, 1'b0, 8'h0, 4'h0, 1'b1, "R10");
    // mixed random sweep against the model (R3, R8, R9, R10 among them)
    for (int t = 0; t < 3000; t++) begin
      logic [31:0] rr;
      rr = $urandom;
      apply($urandom, (t % 4 == 0) ? rr : {rr[31:8], 8'(t % 70)}, 2'($urandom),
            5'($urandom), 1'($urandom), (t % 5 == 0), 8'($urandom), 4'($urandom),
            1'($urandom), "R3_mix");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule